// File: doc/BRIEF.md
# Size-Aware Register File with Banked Stack Pointer

This block holds the general register state of a 32-bit processor core: eight data registers and eight address registers. The last address register is the stack pointer. It is backed by two physical registers, a user one and a supervisor one, and the privilege input selects which of the two is active. Writes carry an operand size and obey rules set by the register class. A data register takes a byte or word write into its low bits only and keeps its upper bits. An address register takes a word write sign-extended to the full width and rejects byte writes. The block has two read ports and one write port. It also has an address stepper for postincrement and predecrement addressing, and a dedicated port pair that reaches the inactive stack pointer for privileged moves.

All ports are plain control and data signals with no handshake. The data path has no back-pressure because every request is accepted and completes in the cycle it is presented. Reads and the stepper's effective address are combinational. Register updates take effect at the next rising clock edge. Logical register index 0 to 7 selects D0 to D7, and index 8 to 15 selects A0 to A7. Size code 0 is byte, 1 is word, 2 is long, and 3 is reserved.

Top module: `sized_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all seventeen physical registers to zero. This covers both stack pointers.
- R2: A write to a data register (index 0 to 7) with size code 0 replaces bits 7:0 only, and with size code 1 replaces bits 15:0 only. The other bits keep their old value. Size code 2 replaces all 32 bits.
- R3: On a write to an address register (index 8 to 15) with size code 0, or on any write with size code 3, `wr_illegal` is high in that same cycle and no register changes.
- R4: A write to an address register with size code 1 stores the 16-bit value sign-extended to 32 bits. Size code 2 stores all 32 bits.
- R5: Each read port returns the selected register masked by its size code, with the upper bits zero. Code 0 gives bits 7:0, code 1 gives bits 15:0, and codes 2 and 3 give all 32 bits.
- R6: Index 15 reaches the user stack pointer when `sup_mode` is 0 and the supervisor stack pointer when it is 1. `osp_rd_data` shows the other, inactive stack pointer, and `osp_wr_en` writes that inactive pointer.
- R7: The stepper uses a step of 1 for size code 0, 2 for code 1 and 4 for codes 2 and 3. When `step_areg` is 7 (A7) and the size code is 0, the step is 2.
- R8: With `step_predec` at 1, `step_ea` equals the old value minus the step, and the register takes that value. With `step_predec` at 0, `step_ea` equals the old value and the register takes the old value plus the step.
- R9: A read port that selects the register being written by an accepted write in the same cycle returns the value after the write. `osp_rd_data` likewise returns `osp_wr_data` while `osp_wr_en` is high.
- R10: When an accepted write and a step target the same physical register in one cycle, the write wins and the step's update is dropped. `step_ea` still reports the step's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sup_mode | input | 1 | Privilege: 1 selects supervisor stack pointer as A7 |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_size | input | 2 | Read port A size code |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data, right-aligned |
| wr_illegal | output | 1 | Write rejected for its size and class |
| step_en | input | 1 | Address step request |
| step_areg | input | 3 | Address register number to step (0 to 7) |
| step_size | input | 2 | Operand size code of the step |
| step_predec | input | 1 | 1 predecrement, 0 postincrement |
| step_ea | output | 32 | Effective address of the step |
| osp_rd_data | output | 32 | Inactive stack pointer value |
| osp_wr_en | input | 1 | Write the inactive stack pointer |
| osp_wr_data | input | 32 | Data for the inactive stack pointer |

## Verification
The bench builds the block with its default parameters: 32-bit registers, eight data registers and eight address registers. This makes the A7 byte-step exception and the 16-bit sign extension reachable, and keeps every one of the 16 logical indices within a 4-bit random draw. A fixed-seed random stream mixes writes, steps and inactive-pointer writes in the same cycles, and it toggles the privilege bit often. This exercises bank selection, bypass and the write-over-step collision together. The directed cases pin down the exact values of the sign-extension boundary, the stack pointer byte step and the reset state.

// File: rtl/sarf_pkg.sv
package sarf_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } opsize_e;
endpackage

// File: rtl/sarf_write_merge.sv
module sarf_write_merge
  import sarf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] new_data,
  input  logic [1:0]    size,
  input  logic          is_addr,
  output logic [DW-1:0] merged,
  output logic          illegal
);
  always_comb begin
    merged  = old_val;
    illegal = 1'b0;
    case (opsize_e'(size))
      SZ_BYTE: begin
        if (is_addr) illegal = 1'b1;
        else         merged  = {old_val[DW-1:8], new_data[7:0]};
      end
      SZ_WORD: begin
        if (is_addr) merged = {{(DW-16){new_data[15]}}, new_data[15:0]};
        else         merged = {old_val[DW-1:16], new_data[15:0]};
      end
      SZ_LONG: merged  = new_data;
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/sarf_step_unit.sv
module sarf_step_unit
  import sarf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base,
  input  logic [1:0]    size,
  input  logic          is_sp,
  input  logic          predec,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] updated
);
  logic [2:0] amt;

  always_comb begin
    case (opsize_e'(size))
      SZ_BYTE: amt = is_sp ? 3'd2 : 3'd1;
      SZ_WORD: amt = 3'd2;
      default: amt = 3'd4;
    endcase
  end

  assign ea      = predec ? (base - DW'(amt)) : base;
  assign updated = predec ? (base - DW'(amt)) : (base + DW'(amt));
endmodule

// File: rtl/sarf_read_port.sv
module sarf_read_port
  import sarf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NPHYS = 17,
  parameter int PW    = 5
) (
  input  logic [NPHYS-1:0][DW-1:0] regs,
  input  logic [PW-1:0]            sel,
  input  logic [1:0]               size,
  input  logic                     byp_en,
  input  logic [PW-1:0]            byp_sel,
  input  logic [DW-1:0]            byp_val,
  output logic [DW-1:0]            data
);
  logic [DW-1:0] src;

  always_comb begin
    if (byp_en && (byp_sel == sel)) src = byp_val;
    else                            src = regs[sel];
    case (opsize_e'(size))
      SZ_BYTE: data = {{(DW-8){1'b0}},  src[7:0]};
      SZ_WORD: data = {{(DW-16){1'b0}}, src[15:0]};
      default: data = src;
    endcase
  end
endmodule

// File: rtl/sized_regfile.sv
module sized_regfile
  import sarf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NDATA = 8,
  parameter int NADDR = 8,
  localparam int NLOG  = NDATA + NADDR,
  localparam int IW    = $clog2(NLOG),
  localparam int AIW   = $clog2(NADDR)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sup_mode,
  input  logic [IW-1:0]  rd_a_idx,
  input  logic [1:0]     rd_a_size,
  output logic [DW-1:0]  rd_a_data,
  input  logic [IW-1:0]  rd_b_idx,
  input  logic [1:0]     rd_b_size,
  output logic [DW-1:0]  rd_b_data,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [1:0]     wr_size,
  input  logic [DW-1:0]  wr_data,
  output logic           wr_illegal,
  input  logic           step_en,
  input  logic [AIW-1:0] step_areg,
  input  logic [1:0]     step_size,
  input  logic           step_predec,
  output logic [DW-1:0]  step_ea,
  output logic [DW-1:0]  osp_rd_data,
  input  logic           osp_wr_en,
  input  logic [DW-1:0]  osp_wr_data
);
  localparam int NPHYS  = NLOG + 1;
  localparam int PW     = $clog2(NPHYS);
  localparam int SP_LOG = NLOG - 1;
  localparam int USP_P  = NLOG - 1;
  localparam int SSP_P  = NLOG;
  localparam int NRD    = 2;

  logic [NPHYS-1:0][DW-1:0] regs;
  logic [NPHYS-1:0][DW-1:0] nxt;

  function automatic logic [PW-1:0] to_phys(input logic [IW-1:0] idx, input logic sup);
    return (idx == IW'(SP_LOG) && sup) ? PW'(SSP_P) : PW'(idx);
  endfunction

  // write path
  logic [PW-1:0] wphys;
  logic          is_addr;
  logic [DW-1:0] wmerged;
  logic          wbad;
  logic          wr_ok;

  assign wphys   = to_phys(wr_idx, sup_mode);
  assign is_addr = (wr_idx >= IW'(NDATA));

  sarf_write_merge #(.DW(DW)) u_merge (
    .old_val (regs[wphys]),
    .new_data(wr_data),
    .size    (wr_size),
    .is_addr (is_addr),
    .merged  (wmerged),
    .illegal (wbad)
  );

  assign wr_ok      = wr_en && !wbad;
  assign wr_illegal = wr_en && wbad;

  // address stepper
  logic [IW-1:0] slog;
  logic [PW-1:0] sphys;
  logic          s_is_sp;
  logic [DW-1:0] s_upd;

  assign slog    = IW'(NDATA) + IW'(step_areg);
  assign sphys   = to_phys(slog, sup_mode);
  assign s_is_sp = (step_areg == AIW'(NADDR - 1));

  sarf_step_unit #(.DW(DW)) u_step (
    .base   (regs[sphys]),
    .size   (step_size),
    .is_sp  (s_is_sp),
    .predec (step_predec),
    .ea     (step_ea),
    .updated(s_upd)
  );

  // inactive stack pointer
  logic [PW-1:0] ophys;
  assign ophys = sup_mode ? PW'(USP_P) : PW'(SSP_P);

  // next-state: step, then write overrides, inactive pointer separately
  always_comb begin
    nxt = regs;
    if (step_en)   nxt[sphys] = s_upd;
    if (wr_ok)     nxt[wphys] = wmerged;
    if (osp_wr_en) nxt[ophys] = osp_wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) regs <= '0;
    else     regs <= nxt;
  end

  // read ports
  logic [NRD-1:0][IW-1:0] r_idx;
  logic [NRD-1:0][1:0]    r_size;
  logic [NRD-1:0][DW-1:0] r_data;

  assign r_idx  = {rd_b_idx, rd_a_idx};
  assign r_size = {rd_b_size, rd_a_size};

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    sarf_read_port #(.DW(DW), .NPHYS(NPHYS), .PW(PW)) u_rd (
      .regs   (regs),
      .sel    (to_phys(r_idx[g], sup_mode)),
      .size   (r_size[g]),
      .byp_en (wr_ok),
      .byp_sel(wphys),
      .byp_val(wmerged),
      .data   (r_data[g])
    );
  end

  assign rd_a_data = r_data[0];
  assign rd_b_data = r_data[1];

  sarf_read_port #(.DW(DW), .NPHYS(NPHYS), .PW(PW)) u_osp_rd (
    .regs   (regs),
    .sel    (ophys),
    .size   (2'd2),
    .byp_en (osp_wr_en),
    .byp_sel(ophys),
    .byp_val(osp_wr_data),
    .data   (osp_rd_data)
  );

  // assertions
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regs[0] == '0 && regs[USP_P] == '0 && regs[SSP_P] == '0)); // R1

  AST_DATA_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !is_addr && wr_size == 2'd0)
      |=> regs[$past(wphys)][DW-1:8] == $past(regs[wphys][DW-1:8])); // R2

  AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (wr_illegal && !(step_en && sphys == wphys))
      |=> regs[$past(wphys)] == $past(regs[wphys])); // R3

  AST_ADDR_WORD_SEXT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_addr && wr_size == 2'd1)
      |=> regs[$past(wphys)][DW-1:16] == {(DW-16){regs[$past(wphys)][15]}}); // R4

  AST_SP_STAYS_EVEN: assert property (@(posedge clk) disable iff (rst)
    (step_en && s_is_sp && !regs[sphys][0] && !(wr_ok && wphys == sphys))
      |=> !regs[$past(sphys)][0]); // R7
endmodule

// File: tb/sized_regfile_tb.sv
module sized_regfile_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        sup_mode;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [1:0]  rd_a_size, rd_b_size, wr_size, step_size;
  logic [31:0] rd_a_data, rd_b_data, wr_data, step_ea, osp_rd_data, osp_wr_data;
  logic        wr_en, wr_illegal, step_en, step_predec, osp_wr_en;
  logic [2:0]  step_areg;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m [0:16];

  always #5 clk = ~clk;

  sized_regfile u_dut (
    .clk(clk), .rst(rst), .sup_mode(sup_mode),
    .rd_a_idx(rd_a_idx), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
    .wr_illegal(wr_illegal),
    .step_en(step_en), .step_areg(step_areg), .step_size(step_size),
    .step_predec(step_predec), .step_ea(step_ea),
    .osp_rd_data(osp_rd_data), .osp_wr_en(osp_wr_en), .osp_wr_data(osp_wr_data)
  );

  function automatic int ph(input int idx, input logic sup);
    return (idx == 15 && sup) ? 16 : idx;
  endfunction

  // {illegal, value}
  function automatic logic [32:0] mrg(input logic [31:0] o, input logic [31:0] d,
                                      input logic [1:0] sz, input logic isa);
    case (sz)
      2'd0: return isa ? {1'b1, o} : {1'b0, o[31:8], d[7:0]};
      2'd1: return isa ? {1'b0, {16{d[15]}}, d[15:0]} : {1'b0, o[31:16], d[15:0]};
      2'd2: return {1'b0, d};
      default: return {1'b1, o};
    endcase
  endfunction

  function automatic logic [31:0] msk(input logic [31:0] v, input logic [1:0] sz);
    case (sz)
      2'd0: return {24'd0, v[7:0]};
      2'd1: return {16'd0, v[15:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [31:0] amt(input logic [1:0] sz, input logic [2:0] r);
    case (sz)
      2'd0: return (r == 3'd7) ? 32'd2 : 32'd1;
      2'd1: return 32'd2;
      default: return 32'd4;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] idx, input logic [1:0] sz);
    logic [32:0] w;
    int p;
    p = ph(idx, sup_mode);
    w = mrg(m[ph(wr_idx, sup_mode)], wr_data, wr_size, wr_idx >= 4'd8);
    if (wr_en && !w[32] && ph(wr_idx, sup_mode) == p) return msk(w[31:0], sz);
    return msk(m[p], sz);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; step_en = 0; osp_wr_en = 0;
    wr_idx = 0; wr_size = 2; wr_data = 0;
    step_areg = 0; step_size = 2; step_predec = 0; osp_wr_data = 0;
  endtask

  // inputs are set after a falling edge; compare, then clock, then update the model
  task automatic cyc(input string tag);
    logic [32:0] w;
    logic [31:0] base, st, eea, oexp;
    int sp, op, wp;
    #1;
    wp = ph(wr_idx, sup_mode);
    sp = ph(8 + step_areg, sup_mode);
    op = sup_mode ? 15 : 16;
    w = mrg(m[wp], wr_data, wr_size, wr_idx >= 4'd8);
    base = m[sp];
    st = amt(step_size, step_areg);
    eea = step_predec ? base - st : base;
    oexp = osp_wr_en ? osp_wr_data : m[op];
    if (!rst) begin
      chk({tag, " rd_a"}, rd_a_data, exp_rd(rd_a_idx, rd_a_size));
      chk({tag, " rd_b"}, rd_b_data, exp_rd(rd_b_idx, rd_b_size));
      chk({tag, " illegal"}, {31'd0, wr_illegal}, {31'd0, wr_en & w[32]});
      chk({tag, " osp"}, osp_rd_data, oexp);
      if (step_en) chk({tag, " ea"}, step_ea, eea);
    end
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 17; i++) m[i] = 0;
    end else begin
      if (step_en) m[sp] = step_predec ? base - st : base + st;
      if (wr_en && !w[32]) m[wp] = w[31:0];
      if (osp_wr_en) m[op] = osp_wr_data;
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] i, input logic [1:0] s, input logic [31:0] d);
    wr_en = 1; wr_idx = i; wr_size = s; wr_data = d;
  endtask

  task automatic rd(input logic [3:0] a, input logic [3:0] b, input logic [1:0] s);
    rd_a_idx = a; rd_b_idx = b; rd_a_size = s; rd_b_size = s;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1; sup_mode = 0; idle(); rd(0, 0, 2);
    for (int i = 0; i < 17; i++) m[i] = 32'hDEAD_BEEF;
    @(negedge clk);
    cyc("reset"); cyc("reset");
    rst = 0;
    // R1: every logical register reads zero, both stack pointers too
    for (int i = 0; i < 8; i++) begin rd(4'(2*i), 4'(2*i+1), 2); cyc("R1"); end
    sup_mode = 1; rd(15, 15, 2); cyc("R1"); sup_mode = 0;

    // R2 and R9: partial data writes, seen on the read port in the same cycle
    wr(3, 2, 32'h1234_5678); rd(3, 3, 2); cyc("R9"); idle();
    wr(3, 0, 32'hFFFF_FFAB); rd(3, 3, 2); cyc("R2 R9"); idle();
    chk("R2 byte", m[3], 32'h1234_56AB);
    wr(3, 1, 32'h0000_CDEF); rd(3, 3, 1); cyc("R2 R5"); idle();
    rd(3, 3, 2); cyc("R2"); chk("R2 word", m[3], 32'h1234_CDEF);

    // R4: word write to address register is sign-extended
    wr(10, 1, 32'h0000_8000); cyc("R4"); idle();
    rd(10, 10, 2); cyc("R4"); chk("R4 sext", rd_a_data, 32'hFFFF_8000);
    wr(10, 1, 32'hABCD_7FFF); cyc("R4"); idle(); chk("R4 pos", m[10], 32'h0000_7FFF);

    // R3: byte write to address register rejected, reserved size rejected
    wr(9, 2, 32'h5555_AAAA); cyc("R3"); idle();
    wr(9, 0, 32'h0000_0011); rd(9, 9, 2); cyc("R3"); idle();
    chk("R3 kept", m[9], 32'h5555_AAAA);
    wr(1, 3, 32'h0000_0011); rd(1, 1, 2); cyc("R3"); idle();

    // R6: stack pointer banking and inactive-pointer access
    sup_mode = 0; wr(15, 2, 32'h0000_1000); cyc("R6"); idle();
    sup_mode = 1; wr(15, 2, 32'h0000_2001); cyc("R6"); idle();
    rd(15, 15, 2); cyc("R6"); chk("R6 ssp", rd_a_data, 32'h0000_2001);
    chk("R6 osp", osp_rd_data, 32'h0000_1000);
    osp_wr_en = 1; osp_wr_data = 32'h0000_3000; cyc("R6 R9"); idle();
    sup_mode = 0; rd(15, 15, 2); cyc("R6"); chk("R6 usp", rd_a_data, 32'h0000_3000);
    sup_mode = 1;
    wr(15, 2, 32'h0000_2000); cyc("R6"); idle();

    // R7 and R8: stack byte step is 2, others 1/2/4
    step_en = 1; step_areg = 7; step_size = 0; step_predec = 1; cyc("R7 R8"); idle();
    chk("R7 sp byte", m[16], 32'h0000_1FFE);
    step_en = 1; step_areg = 7; step_size = 0; step_predec = 0; cyc("R7 R8"); idle();
    chk("R8 post", m[16], 32'h0000_2000);
    wr(11, 2, 32'h0000_0100); cyc("R8"); idle();
    step_en = 1; step_areg = 3; step_size = 0; step_predec = 0; cyc("R7"); idle();
    chk("R7 byte", m[11], 32'h0000_0101);
    step_en = 1; step_areg = 3; step_size = 1; step_predec = 1; cyc("R7"); idle();
    step_en = 1; step_areg = 3; step_size = 2; step_predec = 1; cyc("R7 R8"); idle();
    chk("R7 long", m[11], 32'h0000_00FB);

    // R10: write and step on the same register, the write wins
    wr(11, 2, 32'h0000_0500); step_en = 1; step_areg = 3; step_size = 2; step_predec = 1;
    cyc("R10"); idle();
    chk("R10 write wins", m[11], 32'h0000_0500);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      sup_mode = ($urandom % 4) == 0 ? ~sup_mode : sup_mode;
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      rd_a_size = 2'($urandom); rd_b_size = 2'($urandom);
      wr_en = 1'($urandom); wr_idx = ($urandom % 3 == 0) ? rd_a_idx : 4'($urandom);
      wr_size = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      wr_data = $urandom;
      step_en = 1'($urandom); step_areg = 3'($urandom);
      step_size = 2'($urandom); step_predec = 1'($urandom);
      osp_wr_en = ($urandom % 5 == 0); osp_wr_data = $urandom & 32'hFFFF_FFFE;
      cyc("random R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end
    idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule